// File: doc/BRIEF.md
# BCD Time and Calendar Counter Chain

This block keeps wall-clock time and calendar date as seven packed-BCD fields: seconds, minutes, hours (24-hour form), day of week, day of month, month and a two-digit year. A 32.768 kHz clock enable drives a prescaler. The prescaler produces a one-second pulse that advances the chain, and a 512 Hz pulse that a frequency-test path can route to the seconds LSB. Carries ripple from seconds up to year within the cycle that follows the one-second pulse. The date rolls over at each month's real length, and February gets a 29th day in leap years.

A register interface outside this block reads the field outputs as a parallel snapshot. It writes new time by presenting staged values on the load inputs and pulsing the load strobe for one cycle. That transfer replaces every field at once and restarts the prescaler. An oscillator-stop input freezes both the prescaler and all fields, so that a stored clock draws no counting activity.

Top module: `bcd_rtc_chain`

## Requirements
- R1: During synchronous reset the fields read seconds 0x00, minutes 0x00, hours 0x00, weekday 0x01, date 0x01, month 0x01, year 0x00, and `sec_tick` is low.
- R2: Each one-second pulse advances seconds through BCD 0x00..0x59. A wrap of seconds advances minutes (0x00..0x59), and a wrap of minutes advances hours (0x00..0x23). All carries settle in the same clock cycle.
- R3: When hours wrap, the date and the weekday both advance. The weekday counts 0x01..0x07 and wraps to 0x01.
- R4: The date wraps to 0x01 after 0x30 in months 0x04, 0x06, 0x09 and 0x11, and after 0x31 in the other months except February.
- R5: February wraps after 0x29 when the year is a leap year and after 0x28 otherwise. A year is a leap year when its BCD value is a multiple of four, and 0x00 counts as a leap year.
- R6: A date wrap advances the month (0x01..0x12). A month wrap advances the year (0x00..0x99), and the year wraps to 0x00.
- R7: `sec_tick` pulses high for one cycle once every DIV_SEC cycles in which `tick_32k` is high. Cycles with `tick_32k` low do not advance the prescaler.
- R8: `test_tick` pulses high for one cycle once every DIV_TEST enabled cycles. This gives 512 Hz at the default 32768/64 ratio.
- R9: While `osc_stop` is high, no field changes (unless a load occurs), and `sec_tick` and `test_tick` stay low.
- R10: A high `load_en` writes all seven load inputs into the fields on the next edge. The load overrides a one-second increment in the same cycle. It also clears the prescaler, so the next `sec_tick` comes a full DIV_SEC enabled cycles later.
- R11: A field that holds a non-BCD code, or a value above its maximum, wraps to its minimum on its next increment and passes a carry to the next field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_32k | input | 1 | 32.768 kHz time-base clock enable |
| osc_stop | input | 1 | Freezes the prescaler and all fields |
| load_en | input | 1 | One-cycle strobe that transfers the staged values |
| load_sec | input | 8 | Staged seconds, BCD |
| load_min | input | 8 | Staged minutes, BCD |
| load_hour | input | 8 | Staged hours, BCD |
| load_wday | input | 8 | Staged weekday, BCD |
| load_date | input | 8 | Staged day of month, BCD |
| load_month | input | 8 | Staged month, BCD |
| load_year | input | 8 | Staged year, BCD |
| sec_o | output | 8 | Seconds |
| min_o | output | 8 | Minutes |
| hour_o | output | 8 | Hours |
| wday_o | output | 8 | Weekday |
| date_o | output | 8 | Day of month |
| month_o | output | 8 | Month |
| year_o | output | 8 | Year |
| sec_tick | output | 1 | One-second pulse |
| test_tick | output | 1 | 512 Hz test pulse |

## Verification
The load transfer and the one-second increment can fall in the same cycle. The bench provokes this by watching for `sec_tick` and raising `load_en` during that very cycle. It judges the result by requiring the fields to equal the staged values exactly, not those values plus one second. The stop input can also meet a pending one-second pulse in one cycle. Here the fields must hold, which is checked over a held stop window.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  typedef logic [7:0] bcd_t;

  localparam int NUM_FIELDS = 7;
  localparam int F_SEC   = 0;
  localparam int F_MIN   = 1;
  localparam int F_HOUR  = 2;
  localparam int F_WDAY  = 3;
  localparam int F_DATE  = 4;
  localparam int F_MONTH = 5;
  localparam int F_YEAR  = 6;

  function automatic bcd_t fld_min(int idx);
    case (idx)
      F_WDAY, F_DATE, F_MONTH: fld_min = 8'h01;
      default:                 fld_min = 8'h00;
    endcase
  endfunction

  function automatic bcd_t fld_max(int idx);
    case (idx)
      F_SEC, F_MIN: fld_max = 8'h59;
      F_HOUR:       fld_max = 8'h23;
      F_WDAY:       fld_max = 8'h07;
      F_DATE:       fld_max = 8'h31;
      F_MONTH:      fld_max = 8'h12;
      default:      fld_max = 8'h99;
    endcase
  endfunction

  // multiple of four in BCD: odd tens need units 2/6, even tens need 0/4/8
  function automatic logic is_leap(bcd_t yr);
    is_leap = yr[4] ? (yr[1:0] == 2'b10) : (yr[1:0] == 2'b00);
  endfunction

  function automatic bcd_t month_days(bcd_t mon, logic leap);
    case (mon)
      8'h02:                      month_days = leap ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: month_days = 8'h30;
      default:                    month_days = 8'h31;
    endcase
  endfunction
endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int DIV_SEC  = 32768,
  parameter int DIV_TEST = 64
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic tick_en,
  input  logic stop,
  output logic sec_pulse,
  output logic test_pulse
);
  localparam int CW = $clog2(DIV_SEC);
  localparam int TW = $clog2(DIV_TEST);
  localparam logic [CW-1:0] LAST = CW'(DIV_SEC - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt        <= '0;
      sec_pulse  <= 1'b0;
      test_pulse <= 1'b0;
    end else begin
      sec_pulse  <= 1'b0;
      test_pulse <= 1'b0;
      if (tick_en && !stop) begin
        cnt        <= (cnt == LAST) ? '0 : cnt + 1'b1;
        sec_pulse  <= (cnt == LAST);
        test_pulse <= &cnt[TW-1:0];
      end
    end
  end
endmodule

// File: rtl/rtc_bcd_field.sv
module rtc_bcd_field #(
  parameter logic [7:0] MIN_VAL = 8'h00
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       load,
  input  logic [7:0] load_val,
  input  logic       inc,
  input  logic [7:0] limit,
  output logic [7:0] val,
  output logic       carry
);
  logic       nonbcd;
  logic       wrap;
  logic [7:0] nxt;

  always_comb begin
    nonbcd = (val[3:0] > 4'd9) || (val[7:4] > 4'd9);
    wrap   = nonbcd || (val >= limit);
    nxt    = (val[3:0] == 4'd9) ? {val[7:4] + 4'd1, 4'd0}
                                : {val[7:4], val[3:0] + 4'd1};
    carry  = inc && wrap;
  end

  always_ff @(posedge clk) begin
    if (rst)       val <= MIN_VAL;
    else if (load) val <= load_val;
    else if (inc)  val <= wrap ? MIN_VAL : nxt;
  end
endmodule

// File: rtl/bcd_rtc_chain.sv
module bcd_rtc_chain
  import rtc_pkg::*;
#(
  parameter int DIV_SEC  = 32768,
  parameter int DIV_TEST = 64
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick_32k,
  input  logic       osc_stop,
  input  logic       load_en,
  input  logic [7:0] load_sec,
  input  logic [7:0] load_min,
  input  logic [7:0] load_hour,
  input  logic [7:0] load_wday,
  input  logic [7:0] load_date,
  input  logic [7:0] load_month,
  input  logic [7:0] load_year,
  output logic [7:0] sec_o,
  output logic [7:0] min_o,
  output logic [7:0] hour_o,
  output logic [7:0] wday_o,
  output logic [7:0] date_o,
  output logic [7:0] month_o,
  output logic [7:0] year_o,
  output logic       sec_tick,
  output logic       test_tick
);
  bcd_t                  fld   [NUM_FIELDS];
  bcd_t                  ldv   [NUM_FIELDS];
  bcd_t                  lim   [NUM_FIELDS];
  logic [NUM_FIELDS-1:0] inc;
  logic [NUM_FIELDS-1:0] carry;

  rtc_prescaler #(.DIV_SEC(DIV_SEC), .DIV_TEST(DIV_TEST)) presc_i (
    .clk        (clk),
    .rst        (rst),
    .clr        (load_en),
    .tick_en    (tick_32k),
    .stop       (osc_stop),
    .sec_pulse  (sec_tick),
    .test_pulse (test_tick)
  );

  always_comb begin
    ldv[F_SEC]   = load_sec;
    ldv[F_MIN]   = load_min;
    ldv[F_HOUR]  = load_hour;
    ldv[F_WDAY]  = load_wday;
    ldv[F_DATE]  = load_date;
    ldv[F_MONTH] = load_month;
    ldv[F_YEAR]  = load_year;
  end

  // carry routing: the weekday and the date both follow the hour wrap
  always_comb begin
    inc[F_SEC]   = sec_tick && !osc_stop && !load_en;
    inc[F_MIN]   = carry[F_SEC];
    inc[F_HOUR]  = carry[F_MIN];
    inc[F_WDAY]  = carry[F_HOUR];
    inc[F_DATE]  = carry[F_HOUR];
    inc[F_MONTH] = carry[F_DATE];
    inc[F_YEAR]  = carry[F_MONTH];
  end

  for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_field
    localparam bcd_t MINV = fld_min(g);
    if (g == F_DATE) begin : g_cal
      always_comb lim[g] = month_days(fld[F_MONTH], is_leap(fld[F_YEAR]));
    end else begin : g_fix
      always_comb lim[g] = fld_max(g);
    end
    rtc_bcd_field #(.MIN_VAL(MINV)) field_i (
      .clk      (clk),
      .rst      (rst),
      .load     (load_en),
      .load_val (ldv[g]),
      .inc      (inc[g]),
      .limit    (lim[g]),
      .val      (fld[g]),
      .carry    (carry[g])
    );
  end

  assign sec_o   = fld[F_SEC];
  assign min_o   = fld[F_MIN];
  assign hour_o  = fld[F_HOUR];
  assign wday_o  = fld[F_WDAY];
  assign date_o  = fld[F_DATE];
  assign month_o = fld[F_MONTH];
  assign year_o  = fld[F_YEAR];
endmodule

// File: rtl/rtc_chain_checker.sv
module rtc_chain_checker (
  input logic       clk,
  input logic       rst,
  input logic       osc_stop,
  input logic       load_en,
  input logic [7:0] load_sec,
  input logic [7:0] load_date,
  input logic [7:0] sec_o,
  input logic [7:0] min_o,
  input logic [7:0] hour_o,
  input logic [7:0] wday_o,
  input logic [7:0] date_o,
  input logic [7:0] month_o,
  input logic [7:0] year_o,
  input logic       sec_tick,
  input logic       test_tick
);
  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (sec_o == 8'h00 && wday_o == 8'h01 && date_o == 8'h01 && !sec_tick));

  assert_sec_only_on_tick_R2: assert property (@(posedge clk) disable iff (rst)
    (!sec_tick && !load_en) |=> $stable(sec_o));

  assert_wday_follows_date_R3: assert property (@(posedge clk) disable iff (rst)
    (!$stable(date_o) && !$past(load_en)) |-> !$stable(wday_o));

  assert_tick_single_R7: assert property (@(posedge clk) disable iff (rst)
    sec_tick |=> !sec_tick);

  assert_stop_freeze_R9: assert property (@(posedge clk) disable iff (rst)
    (osc_stop && !load_en) |=> ($stable(sec_o) && $stable(min_o) && $stable(hour_o) &&
      $stable(date_o) && $stable(month_o) && $stable(year_o) && !sec_tick && !test_tick));

  assert_load_transfer_R10: assert property (@(posedge clk) disable iff (rst)
    load_en |=> (sec_o == $past(load_sec) && date_o == $past(load_date) && !sec_tick));
endmodule

bind bcd_rtc_chain rtc_chain_checker chk_i (
  .clk       (clk),
  .rst       (rst),
  .osc_stop  (osc_stop),
  .load_en   (load_en),
  .load_sec  (load_sec),
  .load_date (load_date),
  .sec_o     (sec_o),
  .min_o     (min_o),
  .hour_o    (hour_o),
  .wday_o    (wday_o),
  .date_o    (date_o),
  .month_o   (month_o),
  .year_o    (year_o),
  .sec_tick  (sec_tick),
  .test_tick (test_tick)
);

// File: tb/bcd_rtc_chain_tb_top.sv
module bcd_rtc_chain_tb_top;
  localparam int DIV_SEC  = 16;
  localparam int DIV_TEST = 4;
  localparam int WDOG     = 150000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick_32k = 1'b1;
  logic osc_stop = 1'b0;
  logic load_en = 1'b0;
  logic [7:0] l_sec = 0, l_min = 0, l_hour = 0, l_wday = 0, l_date = 0, l_mon = 0, l_year = 0;
  logic [7:0] sec_o, min_o, hour_o, wday_o, date_o, month_o, year_o;
  logic sec_tick, test_tick;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  bcd_rtc_chain #(.DIV_SEC(DIV_SEC), .DIV_TEST(DIV_TEST)) dut_i (
    .clk(clk), .rst(rst), .tick_32k(tick_32k), .osc_stop(osc_stop), .load_en(load_en),
    .load_sec(l_sec), .load_min(l_min), .load_hour(l_hour), .load_wday(l_wday),
    .load_date(l_date), .load_month(l_mon), .load_year(l_year),
    .sec_o(sec_o), .min_o(min_o), .hour_o(hour_o), .wday_o(wday_o),
    .date_o(date_o), .month_o(month_o), .year_o(year_o),
    .sec_tick(sec_tick), .test_tick(test_tick)
  );

  function automatic logic [55:0] now();
    return {year_o, month_o, date_o, wday_o, hour_o, min_o, sec_o};
  endfunction

  task automatic check(input string req, input logic [55:0] act, input logic [55:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // fields given as {year,month,date,wday,hour,min,sec}
  task automatic load_time(input logic [55:0] t);
    {l_year, l_mon, l_date, l_wday, l_hour, l_min, l_sec} = t;
    load_en = 1'b1;
    @(negedge clk);
    load_en = 1'b0;
  endtask

  task automatic wait_secs(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      while (!sec_tick) @(negedge clk);
    end
    @(negedge clk);
  endtask

  task automatic t_reset();
    check("R1 reset fields", now(), 56'h00_01_01_01_00_00_00);
    check("R1 reset tick", {55'd0, sec_tick}, 56'd0);
  endtask

  task automatic t_time_digits();
    load_time(56'h21_03_10_02_00_00_09); wait_secs(1);
    check("R2 units carry", now(), 56'h21_03_10_02_00_00_10);
    load_time(56'h21_03_10_02_00_09_59); wait_secs(1);
    check("R2 minute carry", now(), 56'h21_03_10_02_00_10_00);
    load_time(56'h21_03_10_02_09_59_59); wait_secs(1);
    check("R2 hour carry", now(), 56'h21_03_10_02_10_00_00);
  endtask

  task automatic t_rollover();
    load_time(56'h99_12_31_07_23_59_58); wait_secs(1);
    check("R2 seconds to 59", now(), 56'h99_12_31_07_23_59_59);
    wait_secs(1);
    check("R3 R6 full wrap", now(), 56'h00_01_01_01_00_00_00);
    load_time(56'h21_06_14_03_23_59_59); wait_secs(1);
    check("R3 weekday with date", now(), 56'h21_06_15_04_00_00_00);
  endtask

  task automatic t_months();
    load_time(56'h21_04_30_03_23_59_59); wait_secs(1);
    check("R4 April 30", now(), 56'h21_05_01_04_00_00_00);
    load_time(56'h21_01_30_03_23_59_59); wait_secs(1);
    check("R4 January 31 exists", now(), 56'h21_01_31_04_00_00_00);
    load_time(56'h21_11_30_03_23_59_59); wait_secs(1);
    check("R4 November 30", now(), 56'h21_12_01_04_00_00_00);
    load_time(56'h21_08_31_03_23_59_59); wait_secs(1);
    check("R4 August 31", now(), 56'h21_09_01_04_00_00_00);
  endtask

  task automatic feb_case(input logic [7:0] yr, input logic [7:0] d, input logic [55:0] exp);
    load_time({yr, 8'h02, d, 8'h05, 24'h23_59_59}); wait_secs(1);
    check("R5 February", now(), exp);
  endtask

  task automatic t_leap();
    feb_case(8'h24, 8'h28, 56'h24_02_29_06_00_00_00);
    feb_case(8'h23, 8'h28, 56'h23_03_01_06_00_00_00);
    feb_case(8'h00, 8'h28, 56'h00_02_29_06_00_00_00);
    feb_case(8'h10, 8'h28, 56'h10_03_01_06_00_00_00);
    feb_case(8'h12, 8'h28, 56'h12_02_29_06_00_00_00);
    feb_case(8'h96, 8'h29, 56'h96_03_01_06_00_00_00);
  endtask

  task automatic t_prescaler();
    int n;
    logic [55:0] snap;
    load_time(56'h21_03_10_02_00_00_00);
    n = 1;
    while (!sec_tick) begin @(negedge clk); n++; end
    check("R10 full second after load", 56'(n), 56'(DIV_SEC + 1));
    n = 0;
    do begin @(negedge clk); n++; end while (!sec_tick);
    check("R7 second period", 56'(n), 56'(DIV_SEC));
    @(negedge clk);
    snap = now();
    tick_32k = 1'b0;
    n = 0;
    for (int i = 0; i < 3 * DIV_SEC; i++) begin
      @(negedge clk);
      if (sec_tick || test_tick) n++;
    end
    check("R7 enable low stalls", {now(), 8'(n)} >> 8, snap);
    check("R7 no pulses when disabled", 56'(n), 56'd0);
    tick_32k = 1'b1;
  endtask

  task automatic t_test_tick();
    int gap, cnt;
    load_time(56'h21_03_10_02_00_00_00);
    while (!test_tick) @(negedge clk);
    gap = 0;
    do begin @(negedge clk); gap++; end while (!test_tick);
    check("R8 test period", 56'(gap), 56'(DIV_TEST));
    while (!sec_tick) @(negedge clk);
    cnt = 0;
    do begin @(negedge clk); if (test_tick) cnt++; end while (!sec_tick);
    check("R8 test pulses per second", 56'(cnt), 56'(DIV_SEC / DIV_TEST));
  endtask

  task automatic t_stop();
    logic [55:0] snap;
    int n;
    load_time(56'h21_03_10_02_00_00_30);
    while (!sec_tick) @(negedge clk);
    osc_stop = 1'b1;
    snap = now();
    n = 0;
    for (int i = 0; i < 3 * DIV_SEC; i++) begin
      @(negedge clk);
      if (sec_tick || test_tick) n++;
    end
    check("R9 fields frozen", now(), snap);
    check("R9 pulses frozen", 56'(n), 56'd0);
    osc_stop = 1'b0;
    wait_secs(1);
    check("R9 resumes", now(), 56'h21_03_10_02_00_00_31);
  endtask

  task automatic t_collide();
    load_time(56'h21_03_10_02_00_00_05);
    while (!sec_tick) @(negedge clk);
    load_time(56'h22_07_04_01_12_34_56);
    check("R10 load beats increment", now(), 56'h22_07_04_01_12_34_56);
  endtask

  task automatic t_illegal();
    load_time(56'h21_03_10_02_00_10_5C); wait_secs(1);
    check("R11 non-BCD seconds", now(), 56'h21_03_10_02_00_11_00);
    load_time(56'h21_03_05_02_27_59_59); wait_secs(1);
    check("R11 hour above max", now(), 56'h21_03_06_03_00_00_00);
    load_time(56'h21_04_31_02_23_59_59); wait_secs(1);
    check("R11 date above month length", now(), 56'h21_05_01_03_00_00_00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst = 1'b0;
    @(negedge clk);
    t_time_digits();
    t_rollover();
    t_months();
    t_leap();
    t_prescaler();
    t_test_tick();
    t_stop();
    t_collide();
    t_illegal();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > WDOG) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected below %0d", cycles, WDOG);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule